// File: doc/BRIEF.md
# Page-Confined DMA Bus Master

This block copies a run of 32-bit words between a peripheral stream and memory on a shared bus, with no processor work per word. Software loads a start byte address, a word count and a direction into four small registers, then writes a start bit. The engine checks that the whole run fits inside one 4 KiB physical page. If it fits, the engine raises its bus request and waits for the arbiter's grant. It then issues one bus beat per word at consecutive word addresses and keeps ownership of the bus until the final beat has been accepted.

One of two events ends every job: normal completion or an error. An error is a run that would cross a page, a bus error response, or a slave that holds off a beat for too long. Each outcome sets a sticky status flag, and the flag drives the interrupt line until software clears it by writing a one to it. In the peripheral-to-memory direction, the engine pulls one word from the peripheral stream before each write beat. In the memory-to-peripheral direction, it pushes each word it reads to the peripheral with a one-cycle strobe.

Top module: `dma_page_mover`

## Requirements
- R1: After reset, `bus_req`, `bus_valid`, `per_out_put` and `irq` are low, and the status register reads 0.
- R2: Register select 0 holds the start byte address, whose two low bits always read 0. Select 1 holds the word count (low 16 bits). Select 2 is control: bit 1 is the direction (1 = memory to peripheral, 0 = peripheral to memory), and writing bit 0 as 1 starts a job. Select 3 is status: bit 0 busy, bit 1 done, bit 2 error. Read data appears on the cycle after the read strobe.
- R3: A started job raises `bus_req` and issues no bus beat until `bus_gnt` is seen.
- R4: A job of N words issues exactly N accepted beats at start address + 4·k. Each beat writes the next peripheral word to memory, or delivers the memory word to the peripheral output, depending on the direction.
- R5: `bus_req` stays high until the last beat is accepted and then drops. No beat is issued while `bus_req` is low.
- R6: A job whose word offset within its 4 KiB page plus its count exceeds 1024 sets error and never raises `bus_req`. No beat of an accepted job leaves the starting page.
- R7: A job with a count of zero sets done without raising `bus_req`.
- R8: A bus error response ends the job at once: `bus_req` drops and error is set.
- R9: A beat may wait up to 256 not-ready cycles. On the 257th consecutive not-ready cycle the job aborts, `bus_req` drops and error is set.
- R10: `irq` is high exactly while done or error is set. Writing 1 to status bit 1 or bit 2 clears that flag.
- R11: While a job is busy, writes to the address, count and control registers are ignored.
- R12: While a beat waits for `bus_ready`, its address, write data and write-enable stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Completion or error interrupt |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant from arbiter |
| bus_valid | output | 1 | Beat in progress |
| bus_we | output | 1 | Beat is a memory write |
| bus_addr | output | 32 | Beat byte address |
| bus_wdata | output | 32 | Beat write data |
| bus_rdata | input | 32 | Read data from slave |
| bus_ready | input | 1 | Slave accepts the beat |
| bus_err | input | 1 | Slave error response |
| per_in_valid | input | 1 | Peripheral source has a word |
| per_in_data | input | 32 | Peripheral source word |
| per_in_take | output | 1 | Engine consumes the source word this cycle |
| per_out_put | output | 1 | Strobe delivering a word to the peripheral |
| per_out_data | output | 32 | Word delivered to the peripheral |

## Verification
The in-RTL properties watch, on every cycle, the rules that link the bus signals to each other: a beat only happens under ownership, it holds still while the slave stalls, and it stays inside the starting page. They also check that bus ownership is given up on an error response or a stall timeout, that no beat happens while waiting for the grant, and that locked registers keep their contents while busy. What no property can show is end-to-end data movement. Only the bench scenarios show that the right words land at the right addresses in both directions, that the beat count matches the count register, that a page-crossing or zero-length job never touches the bus, and where the exact 256/257-cycle stall boundary falls.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_FETCH = 2'd2,
    ST_BEAT  = 2'd3
  } eng_state_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              done_set,
  input  logic              err_set,
  output logic              start_o,
  output logic [ADDR_W-3:0] start_word,
  output logic [CNT_W-1:0]  start_cnt,
  output logic              dir_o,
  output logic              irq
);
  import dma_pkg::*;

  logic [ADDR_W-3:0] word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              dir_q;
  logic              done_q;
  logic              err_q;
  logic              start_q;
  logic [REG_W-1:0]  rdata_q;
  logic              locked;
  logic              cfg_wr;
  logic              stat_wr;

  // the pending start pulse counts as busy so its job's setup cannot shift
  assign locked  = busy | start_q;
  assign cfg_wr  = reg_wr && !locked;
  assign stat_wr = reg_wr && (reg_sel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (cfg_wr) begin
        case (reg_sel)
          SEL_ADDR: word_q <= reg_wdata[ADDR_W-1:2];
          SEL_CNT:  cnt_q  <= reg_wdata[CNT_W-1:0];
          SEL_CTRL: begin
            dir_q   <= reg_wdata[1];
            start_q <= reg_wdata[0];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (done_set)                      done_q <= 1'b1;
      else if (stat_wr && reg_wdata[1])  done_q <= 1'b0;
      if (err_set)                       err_q  <= 1'b1;
      else if (stat_wr && reg_wdata[2])  err_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (reg_sel)
        SEL_ADDR: rdata_q <= REG_W'({word_q, 2'b00});
        SEL_CNT:  rdata_q <= REG_W'(cnt_q);
        SEL_CTRL: rdata_q <= REG_W'({dir_q, 1'b0});
        default:  rdata_q <= REG_W'({err_q, done_q, busy});
      endcase
    end
  end

  assign reg_rdata  = rdata_q;
  assign start_o    = start_q;
  assign start_word = word_q;
  assign start_cnt  = cnt_q;
  assign dir_o      = dir_q;
  assign irq        = done_q | err_q;

  // R10
  w1c_done_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && reg_wdata[1] && !done_set) |=> !done_q);

  // R10
  w1c_err_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && reg_wdata[2] && !err_set) |=> !err_q);

  // R11
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(word_q) && $stable(cnt_q) && $stable(dir_q)));
endmodule

// File: rtl/dma_pagechk.sv
module dma_pagechk #(
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic [PAGE_BITS-3:0] word_off,
  input  logic [CNT_W-1:0]     words,
  output logic                 crosses,
  output logic                 empty
);
  localparam int OFF_W = PAGE_BITS - 2;
  localparam int SUM_W = ((CNT_W > OFF_W) ? CNT_W : OFF_W) + 1;
  localparam int WORDS_PER_PAGE = 1 << OFF_W;

  logic [SUM_W-1:0] reach;

  assign reach   = SUM_W'(word_off) + SUM_W'(words);
  assign crosses = reach > SUM_W'(WORDS_PER_PAGE);
  assign empty   = (words == '0);
endmodule

// File: rtl/dma_stallcnt.sv
module dma_stallcnt #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (run && (cnt_q != W'(LIMIT))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int PAGE_BITS   = 12,
  parameter int STALL_LIMIT = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-3:0] start_word,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic              dir_rd,
  output logic              busy,
  output logic              done_pulse,
  output logic              err_pulse,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_err,
  input  logic              per_in_valid,
  input  logic [DATA_W-1:0] per_in_data,
  output logic              per_in_take,
  output logic              per_out_put,
  output logic [DATA_W-1:0] per_out_data
);
  import dma_pkg::*;

  localparam int PAGE_W = ADDR_W - PAGE_BITS;

  eng_state_t        st;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              rd_q;
  logic [PAGE_W-1:0] page_q;
  logic              req_q;
  logic              valid_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              put_q;
  logic [DATA_W-1:0] odata_q;
  logic              done_q;
  logic              err_q;
  logic              crosses;
  logic              empty;
  logic              stalled;
  logic              expired;
  logic              in_beat;

  dma_pagechk #(
    .CNT_W     (CNT_W),
    .PAGE_BITS (PAGE_BITS)
  ) u_pagechk (
    .word_off (start_word[PAGE_BITS-3:0]),
    .words    (start_cnt),
    .crosses  (crosses),
    .empty    (empty)
  );

  assign in_beat = (st == ST_BEAT);
  assign stalled = in_beat && !bus_ready && !bus_err;

  dma_stallcnt #(
    .LIMIT (STALL_LIMIT)
  ) u_stall (
    .clk     (clk),
    .rst     (rst),
    .run     (stalled),
    .clr     (!in_beat),
    .expired (expired)
  );

  assign per_in_take = (st == ST_FETCH) && !rd_q && per_in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      rd_q    <= 1'b0;
      page_q  <= '0;
      req_q   <= 1'b0;
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      put_q   <= 1'b0;
      odata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      put_q  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (crosses) begin
              err_q <= 1'b1;
            end else if (empty) begin
              done_q <= 1'b1;
            end else begin
              addr_q <= {start_word, 2'b00};
              page_q <= start_word[ADDR_W-3:PAGE_BITS-2];
              left_q <= start_cnt;
              rd_q   <= dir_rd;
              req_q  <= 1'b1;
              st     <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (bus_gnt) st <= ST_FETCH;
        end
        ST_FETCH: begin
          if (rd_q) begin
            valid_q <= 1'b1;
            we_q    <= 1'b0;
            st      <= ST_BEAT;
          end else if (per_in_valid) begin
            wdata_q <= per_in_data;
            valid_q <= 1'b1;
            we_q    <= 1'b1;
            st      <= ST_BEAT;
          end
        end
        ST_BEAT: begin
          if (bus_err || (!bus_ready && expired)) begin
            valid_q <= 1'b0;
            req_q   <= 1'b0;
            err_q   <= 1'b1;
            st      <= ST_IDLE;
          end else if (bus_ready) begin
            valid_q <= 1'b0;
            if (!we_q) begin
              put_q   <= 1'b1;
              odata_q <= bus_rdata;
            end
            addr_q <= addr_q + ADDR_W'(4);
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) begin
              req_q  <= 1'b0;
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              st <= ST_FETCH;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (st != ST_IDLE);
  assign done_pulse   = done_q;
  assign err_pulse    = err_q;
  assign bus_req      = req_q;
  assign bus_valid    = valid_q;
  assign bus_we       = we_q;
  assign bus_addr     = addr_q;
  assign bus_wdata    = wdata_q;
  assign per_out_put  = put_q;
  assign per_out_data = odata_q;

  // R5
  owned_beat_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> req_q);

  // R12
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !bus_ready && !bus_err && !expired) |=>
      (valid_q && $stable(addr_q) && $stable(wdata_q) && $stable(we_q)));

  // R6
  page_stay_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (addr_q[ADDR_W-1:PAGE_BITS] == page_q));

  // R3
  grant_first_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_REQ) && !bus_gnt) |=> !valid_q);

  // R8
  err_release_chk: assert property (@(posedge clk) disable iff (rst)
    (in_beat && bus_err) |=> (!req_q && err_q));

  // R9
  stall_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (stalled && expired) |=> (!req_q && !valid_q && err_q));
endmodule

// File: rtl/dma_page_mover.sv
module dma_page_mover #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int REG_W       = 32,
  parameter int CNT_W       = 16,
  parameter int PAGE_BITS   = 12,
  parameter int STALL_LIMIT = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_err,
  input  logic              per_in_valid,
  input  logic [DATA_W-1:0] per_in_data,
  output logic              per_in_take,
  output logic              per_out_put,
  output logic [DATA_W-1:0] per_out_data
);
  logic              busy;
  logic              done_pulse;
  logic              err_pulse;
  logic              start;
  logic [ADDR_W-3:0] start_word;
  logic [CNT_W-1:0]  start_cnt;
  logic              dir_rd;

  dma_regs #(
    .REG_W  (REG_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .done_set   (done_pulse),
    .err_set    (err_pulse),
    .start_o    (start),
    .start_word (start_word),
    .start_cnt  (start_cnt),
    .dir_o      (dir_rd),
    .irq        (irq)
  );

  dma_engine #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .PAGE_BITS   (PAGE_BITS),
    .STALL_LIMIT (STALL_LIMIT)
  ) u_engine (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .start_word   (start_word),
    .start_cnt    (start_cnt),
    .dir_rd       (dir_rd),
    .busy         (busy),
    .done_pulse   (done_pulse),
    .err_pulse    (err_pulse),
    .bus_req      (bus_req),
    .bus_gnt      (bus_gnt),
    .bus_valid    (bus_valid),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_ready    (bus_ready),
    .bus_err      (bus_err),
    .per_in_valid (per_in_valid),
    .per_in_data  (per_in_data),
    .per_in_take  (per_in_take),
    .per_out_put  (per_out_put),
    .per_out_data (per_out_data)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!bus_req && !bus_valid && !irq && !per_out_put));
endmodule

// File: tb/dma_page_mover_test.sv
module dma_page_mover_test;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  cnt;
    logic        dir;
    logic [8:0]  stall;
    logic [7:0]  errb;
    logic        exp_err;
    logic [7:0]  exp_beats;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TAB [NV] = '{
    '{16'h0100, 8'd4, 1'b0, 9'd0, 8'hFF, 1'b0, 8'd4},
    '{16'h0200, 8'd3, 1'b1, 9'd2, 8'hFF, 1'b0, 8'd3},
    '{16'h0FF8, 8'd2, 1'b0, 9'd0, 8'hFF, 1'b0, 8'd2},
    '{16'h0FF8, 8'd3, 1'b0, 9'd0, 8'hFF, 1'b1, 8'd0},
    '{16'h0300, 8'd5, 1'b1, 9'd0, 8'd2,  1'b1, 8'd2},
    '{16'h0040, 8'd0, 1'b1, 9'd0, 8'hFF, 1'b0, 8'd0},
    '{16'h1FF0, 8'd4, 1'b0, 9'd1, 8'hFF, 1'b0, 8'd4},
    '{16'h0403, 8'd2, 1'b1, 9'd0, 8'hFF, 1'b0, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, bus_req, bus_valid, bus_we;
  logic        bus_gnt = 1'b0, bus_ready = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        per_in_take, per_out_put;
  logic [31:0] per_in_data, per_out_data;

  int total = 0, bad = 0, cyc = 0;
  int stall_n = 0, err_beat = 255, wcnt = 0, beat_no = 0;
  int beats = 0, src_k = 0, ncap = 0, orphan = 0;
  logic req_seen = 1'b0, take_prev = 1'b0, clr_mon = 1'b0, gnt_hold = 1'b0;
  logic [31:0] mem [2048];
  logic [31:0] cap [16];

  dma_page_mover uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .per_in_valid(1'b1),
    .per_in_data(per_in_data), .per_in_take(per_in_take),
    .per_out_put(per_out_put), .per_out_data(per_out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  assign per_in_data = 32'hA500_0000 + 32'(src_k);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // slave, arbiter and peripheral models, all acting on the falling edge
  always @(negedge clk) begin
    bus_ready = 1'b0;
    bus_err   = 1'b0;
    if (clr_mon) begin
      beats = 0; beat_no = 0; src_k = 0; ncap = 0; orphan = 0;
      req_seen = 1'b0; take_prev = 1'b0; wcnt = 0;
    end else begin
      if (take_prev) src_k++;
      take_prev = per_in_take;
      if (per_out_put && ncap < 16) begin cap[ncap] = per_out_data; ncap++; end
      if (bus_req) req_seen = 1'b1;
      if (bus_valid && !bus_req) orphan++;
      if (bus_valid) begin
        if (wcnt == stall_n) begin
          wcnt = 0;
          if (beat_no == err_beat) bus_err = 1'b1;
          else begin
            bus_ready = 1'b1;
            if (bus_we) mem[bus_addr[12:2]] = bus_wdata;
            else bus_rdata = mem[bus_addr[12:2]];
            beats++;
          end
          beat_no++;
        end else wcnt++;
      end else wcnt = 0;
    end
    bus_gnt = bus_req && !gnt_hold;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_sel = s;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic clear_mon();
    @(negedge clk); clr_mon = 1'b1;
    @(negedge clk); clr_mon = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) break;
    end
    chk(irq, req, int'(irq), 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic launch(input logic [31:0] a, input int n, input logic dir);
    clear_mon();
    wr(2'd0, a);
    wr(2'd1, 32'(n));
    wr(2'd2, {30'd0, dir, 1'b1});
  endtask

  task automatic clear_status();
    logic [31:0] v;
    wr(2'd3, 32'h6);
    rd(2'd3, v);
    chk(v == 32'h0, "R10 status cleared by W1C", int'(v), 0);
    chk(!irq, "R10 irq low after clear", int'(irq), 0);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 2048; i++) mem[i] = 32'hC0DE_0000 ^ 32'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_req && !bus_valid && !per_out_put, "R1 bus idle after reset",
        int'({bus_req, bus_valid, per_out_put}), 0);
    chk(!irq, "R1 irq low after reset", int'(irq), 0);
    rd(2'd3, v);
    chk(v == 0, "R1 status zero after reset", int'(v), 0);

    wr(2'd0, 32'h1234_5677);
    rd(2'd0, v);
    chk(v == 32'h1234_5674, "R2 address low bits read zero", int'(v), 32'h1234_5674);
    wr(2'd1, 32'hABCD_5678);
    rd(2'd1, v);
    chk(v == 32'h5678, "R2 count readback", int'(v), 32'h5678);
    wr(2'd2, 32'h2);
    rd(2'd2, v);
    chk(v == 32'h2, "R2 direction readback", int'(v), 2);

    for (int k = 0; k < NV; k++) begin
      int base;
      stall_n  = int'(TAB[k].stall);
      err_beat = int'(TAB[k].errb);
      base = int'(TAB[k].addr[12:2]);
      launch(32'(TAB[k].addr), int'(TAB[k].cnt), TAB[k].dir);
      wait_irq("R4 job ends with irq");
      rd(2'd3, v);
      chk(v == (TAB[k].exp_err ? 32'h4 : 32'h2), "R4 R6 R7 R8 final status",
          int'(v), TAB[k].exp_err ? 4 : 2);
      chk(beats == int'(TAB[k].exp_beats), "R4 accepted beat count",
          beats, int'(TAB[k].exp_beats));
      chk(req_seen == (TAB[k].exp_beats != 0), "R6 R7 bus request use",
          int'(req_seen), int'(TAB[k].exp_beats != 0));
      chk(!bus_req && orphan == 0, "R5 bus released, no beat unowned",
          int'({bus_req, 8'(orphan)}), 0);
      for (int j = 0; j < int'(TAB[k].exp_beats); j++) begin
        if (TAB[k].dir)
          chk(cap[j] == (32'hC0DE_0000 ^ 32'(base + j)), "R4 word to peripheral",
              int'(cap[j]), int'(32'hC0DE_0000 ^ 32'(base + j)));
        else
          chk(mem[base + j] == 32'hA500_0000 + 32'(j), "R4 word to memory",
              int'(mem[base + j]), int'(32'hA500_0000 + 32'(j)));
      end
      clear_status();
    end

    // R3 grant withheld, R11 locked registers
    stall_n = 0; err_beat = 255; gnt_hold = 1'b1;
    launch(32'h0000_0500, 1, 1'b1);
    repeat (20) @(negedge clk);
    chk(bus_req && beats == 0 && !bus_valid, "R3 no beat before grant",
        int'({bus_req, bus_valid, 8'(beats)}), 32'h200);
    wr(2'd0, 32'h0000_0900);
    wr(2'd1, 32'h7);
    rd(2'd0, v);
    chk(v == 32'h500, "R11 address write ignored while busy", int'(v), 32'h500);
    rd(2'd1, v);
    chk(v == 32'h1, "R11 count write ignored while busy", int'(v), 1);
    rd(2'd3, v);
    chk(v == 32'h1, "R2 busy bit while waiting", int'(v), 1);
    gnt_hold = 1'b0;
    wait_irq("R3 job completes after grant");
    chk(beats == 1, "R3 single beat after grant", beats, 1);
    clear_status();

    // R9 stall boundary
    stall_n = 256;
    launch(32'h0000_0600, 1, 1'b1);
    wait_irq("R9 256-cycle stall finishes");
    rd(2'd3, v);
    chk(v == 32'h2 && beats == 1, "R9 256 not-ready cycles tolerated", int'(v), 2);
    clear_status();
    stall_n = 257;
    launch(32'h0000_0600, 1, 1'b1);
    wait_irq("R9 257-cycle stall ends");
    rd(2'd3, v);
    chk(v == 32'h4 && beats == 0, "R9 257th not-ready cycle aborts", int'(v), 4);
    chk(!bus_req, "R9 bus released on timeout", int'(bus_req), 0);
    clear_status();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule